// File: doc/BRIEF.md
# Per-Processor Timer Control and Status Register

This block is the timer control and status register that sits beside one processor in a small multiprocessor node. Software enables a periodic timer by setting an enable bit in a 32-bit control word. While the timer is enabled, every strobe on the tick input latches a pending flag and raises the interrupt request line. Software acknowledges the interrupt by writing the control word again. Any write clears the pending flag, whatever value it carries.

A read of the control word always shows the processor's own identifier in its lowest four bits, so shared boot code can find out which processor it runs on. One status bit is scrambled on every read by a small linear feedback shift register. Its pattern is fixed, so a test can predict it. A second address window holds an 8-bit interrupt vector that software writes and reads back. Examples of codes are 0xFC for transmit, 0xF8 for receive and 0x80 for an inter-processor interrupt.

Access is through a simple register bus with an address, read and write strobes, and 32-bit data. Read data is registered and appears one cycle after the read strobe.

Top module: `cpu_timer_csr`

## Requirements
- R1: When bit 15 (timer enable) of the stored control word is 0, a tick leaves bit 29 (timer pending) at 0 and `irq` low.
- R2: When the stored bit 15 is 1, a tick sets bit 29 and drives `irq` high from the following cycle. `irq` never rises unless a tick was present in the previous cycle.
- R3: A write with `winSel`=0 and `addr`=0 stores `wrData` as the control word with bit 29 forced to 0. From the next cycle `irq` is low, provided no tick came with the write.
- R4: Bits 3:0 of a control-word read always equal the `cpuId` value present in the read cycle, whatever was written there.
- R5: Bit 16 of each control-word read is XORed with bit 0 of an 8-bit shift register. The register resets to 0x01. After each control-word read it shifts left and takes in, as its new bit 0, the XOR of its bits 7, 5, 4 and 3. Other reads do not move it.
- R6: A write with `winSel`=1 and `addr`=0 stores `wrData[7:0]` as the vector. A read there returns the vector zero-extended to 32 bits. Vector accesses leave the control word unchanged.
- R7: A read at any nonzero `addr`, in either window, returns 0. Writes there change neither register.
- R8: When a tick and a control-word write arrive in the same cycle, the written value is stored, but bit 29 ends at 1 if the bit 15 stored before that edge was 1.
- R9: Synchronous active-high `rst` clears the control word, the vector and `rdData`, reseeds the shift register to 0x01 and drives `irq` low.
- R10: `rdData` takes its new value on the clock edge that samples `rdEn` and holds it while `rdEn` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| winSel | input | 1 | Window select: 0 selects the control window, 1 selects the vector window |
| addr | input | 8 | Byte offset within the selected window |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| tick | input | 1 | One-cycle periodic timer strobe |
| cpuId | input | 4 | Identifier of the owning processor |
| irq | output | 1 | Timer interrupt request, high while bit 29 is set |

## Verification
The properties assume that `rdEn` and `wrEn` are never high in the same cycle. They also assume that `rst` is held high at time zero, so that registered outputs are known before the first property is checked. The bench drives every input on the falling clock edge and keeps the two strobes apart. It asserts reset from the first instant. It combines a tick with a write only in the dedicated collision scenario, where the expected ending is defined.

// File: rtl/cpu_timer_csr_pkg.sv
package cpu_timer_csr_pkg;
  // Decoded access strobes passed from the control module to the datapath.
  typedef struct packed {
    logic csrWr;  // write to control word
    logic csrRd;  // read of control word
    logic vecWr;  // write to vector register
    logic vecRd;  // read of vector register
    logic anyRd;  // any read, defined offset or not
  } regStrobes_t;
endpackage

// File: rtl/cpu_timer_csr_ctrl.sv
module cpu_timer_csr_ctrl
  import cpu_timer_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              winSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output regStrobes_t       strobes
);
  localparam logic [ADDR_W-1:0] REG_OFFSET = '0;

  logic atReg;

  always_comb begin
    atReg         = (addr == REG_OFFSET);
    strobes.csrWr = wrEn && !winSel && atReg;
    strobes.csrRd = rdEn && !winSel && atReg;
    strobes.vecWr = wrEn &&  winSel && atReg;
    strobes.vecRd = rdEn &&  winSel && atReg;
    strobes.anyRd = rdEn;
  end
endmodule

// File: rtl/cpu_timer_csr_dp.sv
module cpu_timer_csr_dp
  import cpu_timer_csr_pkg::*;
#(
  parameter int              DATA_W    = 32,
  parameter int              ID_W      = 4,
  parameter int              VEC_W     = 8,
  parameter int              LFSR_W    = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h01,
  parameter int              EN_BIT    = 15,
  parameter int              PEND_BIT  = 29,
  parameter int              RAND_BIT  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  regStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tick,
  input  logic [ID_W-1:0]   cpuId,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic [DATA_W-1:0] csrQ
);
  localparam int VEC_PAD = DATA_W - VEC_W;

  logic [VEC_W-1:0]  vecQ;
  logic [LFSR_W-1:0] lfsrQ;
  logic [LFSR_W-1:0] lfsrNext;
  logic [DATA_W-1:0] csrNext;
  logic [DATA_W-1:0] csrView;
  logic [DATA_W-1:0] readValue;
  logic              tickHit;

  // Pending is raised by a tick, judged on the enable stored before the edge.
  always_comb begin
    tickHit = tick && csrQ[EN_BIT];
    csrNext = csrQ;
    if (strobes.csrWr) begin
      csrNext           = wrData;
      csrNext[PEND_BIT] = 1'b0;
    end
    if (tickHit) begin
      csrNext[PEND_BIT] = 1'b1;
    end
  end

  // Feedback shift register that scrambles the status bit.
  always_comb begin
    lfsrNext = {lfsrQ[LFSR_W-2:0], ^(lfsrQ & LFSR_TAPS)};
  end

  // Read view: identifier overlay and scrambled status bit.
  always_comb begin
    csrView               = csrQ;
    csrView[ID_W-1:0]     = cpuId;
    csrView[RAND_BIT]     = csrQ[RAND_BIT] ^ lfsrQ[0];
    if (strobes.csrRd) begin
      readValue = csrView;
    end else if (strobes.vecRd) begin
      readValue = {{VEC_PAD{1'b0}}, vecQ};
    end else begin
      readValue = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csrQ   <= '0;
      vecQ   <= '0;
      lfsrQ  <= LFSR_SEED;
      rdData <= '0;
    end else begin
      csrQ <= csrNext;
      if (strobes.vecWr) begin
        vecQ <= wrData[VEC_W-1:0];
      end
      if (strobes.csrRd) begin
        lfsrQ <= lfsrNext;
      end
      if (strobes.anyRd) begin
        rdData <= readValue;
      end
    end
  end

  assign irq = csrQ[PEND_BIT];
endmodule

// File: rtl/cpu_timer_csr.sv
module cpu_timer_csr
  import cpu_timer_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              winSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              tick,
  input  logic [ID_W-1:0]   cpuId,
  output logic              irq
);
  regStrobes_t       strobes;
  logic [DATA_W-1:0] csrQ;

  cpu_timer_csr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .winSel  (winSel),
    .addr    (addr),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .strobes (strobes)
  );

  cpu_timer_csr_dp #(
    .DATA_W (DATA_W),
    .ID_W   (ID_W),
    .VEC_W  (VEC_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .wrData  (wrData),
    .tick    (tick),
    .cpuId   (cpuId),
    .rdData  (rdData),
    .irq     (irq),
    .csrQ    (csrQ)
  );
endmodule

// File: rtl/cpu_timer_csr_checker.sv
module cpu_timer_csr_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              winSel,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData,
  input logic              tick,
  input logic [ID_W-1:0]   cpuId,
  input logic              irq,
  input logic [DATA_W-1:0] csrQ
);
  localparam int EN_BIT = 15;

  logic ctlAt0;
  assign ctlAt0 = !winSel && (addr == '0);

  a_r1_disabled_tick_quiet: assert property (@(posedge clk) disable iff (rst)
    (tick && !csrQ[EN_BIT] && !irq && !wrEn) |=> !irq);

  a_r2_enabled_tick_raises: assert property (@(posedge clk) disable iff (rst)
    (tick && csrQ[EN_BIT]) |=> irq);

  a_r2_irq_needs_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> !$rose(irq));

  a_r3_write_acks: assert property (@(posedge clk) disable iff (rst)
    (wrEn && ctlAt0 && !tick) |=> !irq);

  a_r4_id_overlay: assert property (@(posedge clk) disable iff (rst)
    (rdEn && ctlAt0) |=> (rdData[ID_W-1:0] == $past(cpuId)));

  a_r7_undefined_zero: assert property (@(posedge clk) disable iff (rst)
    (rdEn && addr != '0) |=> (rdData == '0));

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!irq && rdData == '0));

  a_r10_read_hold: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> $stable(rdData));
endmodule

bind cpu_timer_csr cpu_timer_csr_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .ID_W   (ID_W)
) u_checker (
  .clk    (clk),
  .rst    (rst),
  .winSel (winSel),
  .addr   (addr),
  .wrEn   (wrEn),
  .rdEn   (rdEn),
  .rdData (rdData),
  .tick   (tick),
  .cpuId  (cpuId),
  .irq    (irq),
  .csrQ   (csrQ)
);

// File: tb/cpu_timer_csr_bench.sv
module cpu_timer_csr_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        winSel = 1'b0;
  logic [7:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        tick = 1'b0;
  logic [3:0]  cpuId = 4'h5;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  // Bench-side model built from the requirements.
  logic [31:0] mCsr = '0;
  logic [7:0]  mVec = '0;
  logic [7:0]  mLfsr = 8'h01;

  always #5 clk = ~clk;

  cpu_timer_csr u_cpu_timer_csr (
    .clk(clk), .rst(rst), .winSel(winSel), .addr(addr), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .tick(tick),
    .cpuId(cpuId), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // Expected control-word read per R4 and R5; advances the model register.
  function automatic logic [31:0] expCsrRead();
    logic [31:0] v;
    v = mCsr;
    v[3:0] = cpuId;
    v[16] = mCsr[16] ^ mLfsr[0];
    mLfsr = {mLfsr[6:0], mLfsr[7] ^ mLfsr[5] ^ mLfsr[4] ^ mLfsr[3]};
    return v;
  endfunction

  task automatic busWrite(input logic w, input logic [7:0] a, input logic [31:0] d, input logic t);
    @(negedge clk);
    winSel = w; addr = a; wrData = d; wrEn = 1'b1; tick = t;
    @(negedge clk);
    wrEn = 1'b0; tick = 1'b0; addr = '0; winSel = 1'b0;
  endtask

  task automatic busRead(input logic w, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    winSel = w; addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0; addr = '0; winSel = 1'b0;
    d = rdData;
  endtask

  task automatic pulseTick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic writeCsr(input logic [31:0] d);
    busWrite(1'b0, 8'h00, d, 1'b0);
    mCsr = d;
    mCsr[29] = 1'b0;
  endtask

  task automatic readCsrCheck(input string req);
    logic [31:0] d;
    logic [31:0] e;
    e = expCsrRead();
    busRead(1'b0, 8'h00, d);
    check(req, d, e);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    mCsr = '0; mVec = '0; mLfsr = 8'h01;
  endtask

  task automatic testReset();
    check("R9 irq after reset", {31'b0, irq}, 32'h0);
    check("R9 rdData after reset", rdData, 32'h0);
    readCsrCheck("R9 control word after reset");
  endtask

  task automatic testDisabledTick();
    writeCsr(32'h0000_0000);
    pulseTick();
    check("R1 irq stays low when disabled", {31'b0, irq}, 32'h0);
    readCsrCheck("R1 pending clear when disabled");
  endtask

  task automatic testEnabledTick();
    writeCsr(32'h0000_8000);
    readCsrCheck("R3 enable stored");
    pulseTick();
    mCsr[29] = 1'b1;
    check("R2 irq raised by tick", {31'b0, irq}, 32'h1);
    readCsrCheck("R2 pending bit set");
  endtask

  task automatic testWriteAck();
    writeCsr(32'hA000_8A5F);
    check("R3 irq cleared by write", {31'b0, irq}, 32'h0);
    readCsrCheck("R3 stored value with pending cleared");
    pulseTick();
    mCsr[29] = 1'b1;
    check("R2 irq raised again", {31'b0, irq}, 32'h1);
    writeCsr(32'h0000_0000);
    check("R3 any write acks", {31'b0, irq}, 32'h0);
  endtask

  task automatic testCpuId();
    writeCsr(32'h0000_000F);
    for (int i = 0; i < 4; i++) begin
      cpuId = 4'(i * 5 + 2);
      readCsrCheck("R4 identifier overlay");
    end
    cpuId = 4'h5;
  endtask

  task automatic testLfsr();
    writeCsr(32'h0001_0000);
    for (int i = 0; i < 12; i++) begin
      readCsrCheck("R5 scrambled status bit");
    end
  endtask

  task automatic testVector();
    logic [31:0] d;
    busWrite(1'b1, 8'h00, 32'h0000_00FC, 1'b0); mVec = 8'hFC;
    busRead(1'b1, 8'h00, d); check("R6 vector transmit code", d, 32'h0000_00FC);
    busWrite(1'b1, 8'h00, 32'h0000_00F8, 1'b0); mVec = 8'hF8;
    busRead(1'b1, 8'h00, d); check("R6 vector receive code", d, 32'h0000_00F8);
    busWrite(1'b1, 8'h00, 32'hFFFF_FF80, 1'b0); mVec = 8'h80;
    busRead(1'b1, 8'h00, d); check("R6 vector width limited", d, 32'h0000_0080);
    readCsrCheck("R6 control word untouched by vector access");
  endtask

  task automatic testUndefined();
    logic [31:0] d;
    busWrite(1'b0, 8'h04, 32'hFFFF_FFFF, 1'b0);
    busRead(1'b0, 8'h04, d); check("R7 undefined control offset reads zero", d, 32'h0);
    busWrite(1'b1, 8'h08, 32'h0000_0011, 1'b0);
    busRead(1'b1, 8'h08, d); check("R7 undefined vector offset reads zero", d, 32'h0);
    busRead(1'b1, 8'h00, d); check("R7 vector untouched", d, {24'b0, mVec});
    readCsrCheck("R7 control word untouched and shift register not moved");
    check("R7 irq untouched", {31'b0, irq}, 32'h0);
  endtask

  task automatic testTickWrite();
    writeCsr(32'h0000_8000);
    busWrite(1'b0, 8'h00, 32'h0000_8001, 1'b1);
    mCsr = 32'h2000_8001;
    check("R8 tick wins over write", {31'b0, irq}, 32'h1);
    readCsrCheck("R8 written value with pending set");
    writeCsr(32'h0000_0000);
    busWrite(1'b0, 8'h00, 32'h0000_8000, 1'b1);
    mCsr = 32'h0000_8000;
    check("R8 enable judged before edge", {31'b0, irq}, 32'h0);
    readCsrCheck("R8 pending clear when enable was off");
  endtask

  task automatic testReadHold();
    logic [31:0] held;
    logic [31:0] e;
    e = expCsrRead();
    busRead(1'b0, 8'h00, held);
    check("R10 read value", held, e);
    pulseTick();
    mCsr[29] = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 rdData holds without read", rdData, held);
    readCsrCheck("R10 new read shows pending");
  endtask

  task automatic testResetMid();
    logic [31:0] d;
    busWrite(1'b1, 8'h00, 32'h0000_00FC, 1'b0);
    doReset();
    check("R9 irq cleared by reset", {31'b0, irq}, 32'h0);
    check("R9 rdData cleared by reset", rdData, 32'h0);
    busRead(1'b1, 8'h00, d); check("R9 vector cleared", d, 32'h0);
    readCsrCheck("R9 control word and shift register reseeded");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testDisabledTick();
    testEnabledTick();
    testWriteAck();
    testCpuId();
    testLfsr();
    testVector();
    testUndefined();
    testTickWrite();
    testReadHold();
    testResetMid();
    summary();
    $finish;
  end
endmodule